// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block is the command half of an SD host controller. Software writes a 32-bit argument and then a command word over a simple 32-bit register interface. When the command word carries its start flag, the block passes the command index and argument to the card side over a valid/ready request. It then waits for a response strobe that carries the raw response bytes, a byte count and an error bit.

A good reply is packed into four readable response words. Each word holds its bytes most-significant-first. A long reply fills the words in reversed order, so word 0 holds the last four bytes. A reply of the wrong length, or a reply the card reports as failed, is recorded in two places: a sticky fail flag in the stored command word and a command-timeout bit in the host status register.

The status register is cleared by writing ones. A single interrupt output follows the status interrupt bits. A command may ask for a busy-wait interrupt, and that interrupt is raised on success only when the configuration enables it. A `busy` output holds off the next command until the current response has been captured.

Top module: `sdc_cmd_issue`

## Requirements
- R1: After reset the command word, argument, configuration, status and all four response words read as zero, and `irq` and `busy` are low.
- R2: The register map is: command word at offset 0x00, storing bits 15:0 only; argument at 0x04, all 32 bits; response words 0 to 3 at 0x10, 0x14, 0x18 and 0x1C; status at 0x20; configuration at 0x38, storing bits 10:0 only. Any other offset reads zero.
- R3: A write to the command word while idle that has bit 15 set starts a command. `busy` rises on the next cycle. `req_valid` presents bits 5:0 as `req_index` and the stored argument as `req_arg`, and both hold steady until `req_ready`. Bit 15 then reads back as 0. A command-word write with bit 15 clear is stored but issues nothing.
- R4: A 4-byte reply (response byte k at `rsp_data[8k+7:8k]`) sets response word 0 to {byte0, byte1, byte2, byte3} and clears words 1 to 3.
- R5: A 16-byte reply sets word 0 to bytes 12..15, word 1 to bytes 8..11, word 2 to bytes 4..7 and word 3 to bytes 0..3. Each word holds the lowest-numbered of its bytes in bits 31:24.
- R6: When a reply is expected (command bit 10 clear), the reply is an error if its length is zero, if its length is anything other than 4 or 16, or if it is 4 bytes long for a command with bit 9 (long reply) set.
- R7: A reply with `rsp_err` high is an error whatever its length. A command with bit 10 set (no reply) skips the length checks and leaves the response words unchanged.
- R8: On an error, bit 14 of the stored command word and bit 6 of the status register are set, and the response words keep their previous values.
- R9: A successful command with bit 11 (busy-wait) set also sets status bit 10, but only if configuration bit 10 is set. A failed command never sets status bit 10.
- R10: A write to status clears every bit written as 1 and leaves the others. `irq` is high exactly when any of status bits 10, 9 or 8 is set.
- R11: A command-word write while `busy` is high is ignored. `busy` falls on the cycle after the response strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| req_valid | output | 1 | Command request to the card side |
| req_ready | input | 1 | Card side accepts the request |
| req_index | output | 6 | Command index |
| req_arg | output | DATA_W | Command argument |
| rsp_valid | input | 1 | Response strobe |
| rsp_err | input | 1 | Card reports a failed command |
| rsp_len | input | LEN_W | Number of response bytes |
| rsp_data | input | RSP_WORDS*DATA_W | Response bytes, byte k at bits 8k+7:8k |
| busy | output | 1 | Command in flight |
| irq | output | 1 | Interrupt request |

## Verification
Replies are given with distinct byte values in every position. A short reply and a long reply then show whether the byte order inside a word and the word order are each right. The length cases are chosen so that each error rule fires alone: zero bytes, seven bytes, a short reply to a long command, a card error with a good length, and a zero-byte reply to a no-reply command that must pass. The busy-wait command is run with its enable on and off, and once more with a failing reply, to separate the interrupt gating from the error path. A second command written while the first is still waiting for `req_ready` shows whether the in-flight index and stored word are protected.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   // command word field positions
   localparam int CMD_W      = 16;
   localparam int CMD_START  = 15;
   localparam int CMD_FAIL   = 14;
   localparam int CMD_BUSYW  = 11;
   localparam int CMD_NORSP  = 10;
   localparam int CMD_LONG   = 9;
   localparam int IDX_W      = 6;

   // status and configuration layout
   localparam int STS_W        = 11;
   localparam int STS_BUSY_IRQ = 10;
   localparam int STS_BLK_IRQ  = 9;
   localparam int STS_DAT_IRQ  = 8;
   localparam int STS_CMD_TMO  = 6;
   localparam int CFG_W        = 11;
   localparam int CFG_BUSY_EN  = 10;

   // register offsets
   localparam int OFS_CMD  = 'h00;
   localparam int OFS_ARG  = 'h04;
   localparam int OFS_RSP0 = 'h10;
   localparam int OFS_STS  = 'h20;
   localparam int OFS_CFG  = 'h38;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } seq_t;
endpackage

// File: rtl/sdc_issue_seq.sv
module sdc_issue_seq
   import sdc_pkg::*;
#(
   parameter int ARG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic [IDX_W-1:0] idx_in,
   input  logic [ARG_W-1:0] arg_in,
   input  logic             req_ready,
   input  logic             rsp_valid,
   output logic             req_valid,
   output logic [IDX_W-1:0] req_index,
   output logic [ARG_W-1:0] req_arg,
   output logic             busy,
   output logic             done
);
   seq_t state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         req_index <= '0;
         req_arg   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (issue) begin
               state_q   <= ST_REQ;
               req_index <= idx_in;
               req_arg   <= arg_in;
            end
            ST_REQ:  if (req_ready) state_q <= ST_WAIT;
            ST_WAIT: if (rsp_valid) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_valid = (state_q == ST_REQ);
   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_WAIT) && rsp_valid;
endmodule

// File: rtl/sdc_rsp_check.sv
module sdc_rsp_check #(
   parameter int LEN_W       = 5,
   parameter int SHORT_BYTES = 4,
   parameter int LONG_BYTES  = 16
) (
   input  logic             no_rsp,
   input  logic             long_rsp,
   input  logic [LEN_W-1:0] rsp_len,
   input  logic             rsp_err,
   output logic             bad,
   output logic             long_fmt
);
   localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(SHORT_BYTES);
   localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(LONG_BYTES);

   logic len_zero, len_odd, len_short_on_long;

   assign len_zero          = (rsp_len == '0);
   assign len_odd           = (rsp_len != LEN_SHORT) && (rsp_len != LEN_LONG);
   assign len_short_on_long = (rsp_len == LEN_SHORT) && long_rsp;

   assign bad      = rsp_err || (!no_rsp && (len_zero || len_odd || len_short_on_long));
   assign long_fmt = (rsp_len == LEN_LONG);
endmodule

// File: rtl/sdc_rsp_pack.sv
module sdc_rsp_pack #(
   parameter int DATA_W    = 32,
   parameter int RSP_WORDS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          capture,
   input  logic                          long_fmt,
   input  logic [RSP_WORDS*DATA_W-1:0]   rsp_data,
   output logic [RSP_WORDS*DATA_W-1:0]   words_q
);
   localparam int BPW = DATA_W / 8;

   logic [RSP_WORDS*DATA_W-1:0] long_flat;
   logic [RSP_WORDS*DATA_W-1:0] short_flat;

   for (genvar w = 0; w < RSP_WORDS; w++) begin : g_word
      for (genvar j = 0; j < BPW; j++) begin : g_byte
         localparam int LB = (RSP_WORDS - 1 - w) * BPW + j;
         assign long_flat[w*DATA_W + DATA_W - 1 - 8*j -: 8] = rsp_data[8*LB +: 8];
      end
      if (w == 0) begin : g_short_first
         for (genvar j = 0; j < BPW; j++) begin : g_sbyte
            assign short_flat[DATA_W - 1 - 8*j -: 8] = rsp_data[8*j +: 8];
         end
      end else begin : g_short_zero
         assign short_flat[w*DATA_W +: DATA_W] = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       words_q <= '0;
      else if (capture) words_q <= long_fmt ? long_flat : short_flat;
   end
endmodule

// File: rtl/sdc_host_status.sv
module sdc_host_status #(
   parameter int              W        = 11,
   parameter logic [W-1:0]    IRQ_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_en,
   input  logic [W-1:0] clr_bits,
   input  logic [W-1:0] set_bits,
   output logic [W-1:0] sts_q,
   output logic         irq
);
   logic [W-1:0] keep;

   assign keep = clr_en ? ~clr_bits : '1;

   always_ff @(posedge clk) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_q & keep) | set_bits;
   end

   assign irq = |(sts_q & IRQ_MASK);
endmodule

// File: rtl/sdc_cmd_issue.sv
module sdc_cmd_issue
   import sdc_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int RSP_WORDS = 4,
   parameter int LEN_W     = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_wr,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [DATA_W-1:0]           bus_wdata,
   output logic [DATA_W-1:0]           bus_rdata,
   output logic                        req_valid,
   input  logic                        req_ready,
   output logic [IDX_W-1:0]            req_index,
   output logic [DATA_W-1:0]           req_arg,
   input  logic                        rsp_valid,
   input  logic                        rsp_err,
   input  logic [LEN_W-1:0]            rsp_len,
   input  logic [RSP_WORDS*DATA_W-1:0] rsp_data,
   output logic                        busy,
   output logic                        irq
);
   localparam int BPW       = DATA_W / 8;
   localparam int RSP_BYTES = RSP_WORDS * BPW;
   localparam logic [STS_W-1:0] IRQ_MASK =
      STS_W'((1 << STS_BUSY_IRQ) | (1 << STS_BLK_IRQ) | (1 << STS_DAT_IRQ));

   // elaboration-time parameter checks
   if (DATA_W % 8 != 0 || DATA_W < CMD_W) begin : g_bad_data_w
      $error("DATA_W must be a multiple of 8 and hold the command word");
   end
   if (ADDR_W < 6) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the register map");
   end
   if ((1 << LEN_W) <= RSP_BYTES) begin : g_bad_len_w
      $error("LEN_W cannot express the long reply length");
   end
   if (OFS_RSP0 + RSP_WORDS * BPW > OFS_STS) begin : g_bad_words
      $error("response words overlap the status register");
   end

   logic [CMD_W-1:0]            cmd_q;
   logic [DATA_W-1:0]           arg_q;
   logic [CFG_W-1:0]            cfg_q;
   logic [STS_W-1:0]            sts_q;
   logic [RSP_WORDS*DATA_W-1:0] words_q;
   logic                        cmd_wr, issue, done, bad, long_fmt, seq_busy;
   logic [STS_W-1:0]            set_bits;

   assign cmd_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CMD)) && !seq_busy;
   assign issue  = cmd_wr && bus_wdata[CMD_START];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= '0;
         arg_q <= '0;
         cfg_q <= '0;
      end else begin
         if (cmd_wr) begin
            cmd_q            <= bus_wdata[CMD_W-1:0];
            cmd_q[CMD_START] <= 1'b0;
         end else if (done && bad) begin
            cmd_q[CMD_FAIL]  <= 1'b1;
         end
         if (bus_wr && bus_addr == ADDR_W'(OFS_ARG)) arg_q <= bus_wdata;
         if (bus_wr && bus_addr == ADDR_W'(OFS_CFG)) cfg_q <= bus_wdata[CFG_W-1:0];
      end
   end

   sdc_issue_seq #(.ARG_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (issue),
      .idx_in    (bus_wdata[IDX_W-1:0]),
      .arg_in    (arg_q),
      .req_ready (req_ready),
      .rsp_valid (rsp_valid),
      .req_valid (req_valid),
      .req_index (req_index),
      .req_arg   (req_arg),
      .busy      (seq_busy),
      .done      (done)
   );

   sdc_rsp_check #(
      .LEN_W       (LEN_W),
      .SHORT_BYTES (BPW),
      .LONG_BYTES  (RSP_BYTES)
   ) u_check (
      .no_rsp   (cmd_q[CMD_NORSP]),
      .long_rsp (cmd_q[CMD_LONG]),
      .rsp_len  (rsp_len),
      .rsp_err  (rsp_err),
      .bad      (bad),
      .long_fmt (long_fmt)
   );

   sdc_rsp_pack #(.DATA_W(DATA_W), .RSP_WORDS(RSP_WORDS)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (done && !bad && !cmd_q[CMD_NORSP]),
      .long_fmt (long_fmt),
      .rsp_data (rsp_data),
      .words_q  (words_q)
   );

   always_comb begin
      set_bits = '0;
      if (done && bad) set_bits[STS_CMD_TMO] = 1'b1;
      if (done && !bad && cmd_q[CMD_BUSYW] && cfg_q[CFG_BUSY_EN])
         set_bits[STS_BUSY_IRQ] = 1'b1;
   end

   sdc_host_status #(.W(STS_W), .IRQ_MASK(IRQ_MASK)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_en   (bus_wr && bus_addr == ADDR_W'(OFS_STS)),
      .clr_bits (bus_wdata[STS_W-1:0]),
      .set_bits (set_bits),
      .sts_q    (sts_q),
      .irq      (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CMD)) bus_rdata = DATA_W'(cmd_q);
      if (bus_addr == ADDR_W'(OFS_ARG)) bus_rdata = arg_q;
      if (bus_addr == ADDR_W'(OFS_STS)) bus_rdata = DATA_W'(sts_q);
      if (bus_addr == ADDR_W'(OFS_CFG)) bus_rdata = DATA_W'(cfg_q);
      for (int w = 0; w < RSP_WORDS; w++) begin
         if (bus_addr == ADDR_W'(OFS_RSP0 + w * BPW))
            bus_rdata = words_q[w*DATA_W +: DATA_W];
      end
   end

   assign busy = seq_busy;
endmodule

module sdc_cmd_issue_chk
   import sdc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              req_valid,
   input logic              req_ready,
   input logic [IDX_W-1:0]  req_index,
   input logic [DATA_W-1:0] req_arg,
   input logic              rsp_valid,
   input logic              busy,
   input logic              irq
);
   // R3: an idle start write brings up the request on the next cycle
   assert_issue_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && bus_wr && bus_addr == '0 && bus_wdata[CMD_START]) |=> (busy && req_valid));

   // R3: request fields hold until accepted
   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_index) && $stable(req_arg)));

   // R11: a start write during a command does not disturb the request
   assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_wr && bus_addr == '0) |=> (busy && $stable(req_index)));

   // R11: busy only ends after a response strobe
   assert_busy_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(rsp_valid));

   // R9: the interrupt can only rise when a command completes
   assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $fell(busy));
endmodule

bind sdc_cmd_issue sdc_cmd_issue_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_index (req_index),
   .req_arg   (req_arg),
   .rsp_valid (rsp_valid),
   .busy      (busy),
   .irq       (irq)
);

// File: tb/sdc_cmd_issue_tb.sv
module sdc_cmd_issue_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0;
   logic [7:0]   drv_addr = '0, mon_addr = '0, bus_addr;
   logic [31:0]  bus_wdata = '0, bus_rdata;
   logic         req_valid, req_ready = 1'b0;
   logic [5:0]   req_index;
   logic [31:0]  req_arg;
   logic         rsp_valid = 1'b0, rsp_err = 1'b0;
   logic [4:0]   rsp_len = '0;
   logic [127:0] rsp_data = '0;
   logic         busy, irq;

   always #4 clk = ~clk;   // 125 MHz

   assign bus_addr = bus_wr ? drv_addr : mon_addr;

   sdc_cmd_issue u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
      .req_ready(req_ready), .req_index(req_index), .req_arg(req_arg),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_len(rsp_len),
      .rsp_data(rsp_data), .busy(busy), .irq(irq)
   );

   typedef struct {
      int          kind;   // 0 register, 1 irq, 2 busy
      logic [7:0]  addr;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int    n_chk = 0, n_fail = 0;
   logic  mon_busy = 1'b0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic exp_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
      item_t it;
      it.kind = 0; it.addr = a; it.exp = e; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic exp_pin(input int k, input logic e, input string tag);
      item_t it;
      it.kind = k; it.addr = 8'h00; it.exp = {31'b0, e}; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic drain();
      while (q.size() != 0 || mon_busy) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      drain();
      bus_wr = 1'b1; drv_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic card(input int dly, input logic [5:0] eidx, input logic [31:0] earg,
                       input logic [4:0] len, input logic err, input logic [127:0] data,
                       input string tag);
      while (!req_valid) @(negedge clk);
      repeat (dly) @(negedge clk);
      check({tag, " req_index"}, {26'b0, req_index}, {26'b0, eidx});
      check({tag, " req_arg"}, req_arg, earg);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      repeat (dly) @(negedge clk);
      rsp_valid = 1'b1; rsp_len = len; rsp_err = err; rsp_data = data;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_err = 1'b0;
   endtask

   // scoreboard monitor
   always begin
      @(negedge clk);
      if (q.size() != 0 && !bus_wr) begin
         item_t it;
         mon_busy = 1'b1;
         it = q.pop_front();
         mon_addr = it.addr;
         #1;
         case (it.kind)
            0: check(it.tag, bus_rdata, it.exp);
            1: check(it.tag, {31'b0, irq}, it.exp);
            default: check(it.tag, {31'b0, busy}, it.exp);
         endcase
         mon_busy = 1'b0;
      end
   end

   logic [127:0] long_bytes;
   initial begin
      for (int k = 0; k < 16; k++) long_bytes[8*k +: 8] = 8'(8'h10 + k);
   end

   initial begin
      #(8 * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      exp_reg(8'h00, 0, "R1 cmd"); exp_reg(8'h04, 0, "R1 arg");
      exp_reg(8'h10, 0, "R1 rsp0"); exp_reg(8'h14, 0, "R1 rsp1");
      exp_reg(8'h18, 0, "R1 rsp2"); exp_reg(8'h1C, 0, "R1 rsp3");
      exp_reg(8'h20, 0, "R1 sts"); exp_reg(8'h38, 0, "R1 cfg");
      exp_pin(1, 1'b0, "R1 irq"); exp_pin(2, 1'b0, "R1 busy");

      // R2 register widths and unmapped offset
      wr(8'h38, 32'hFFFF_FFFF);
      exp_reg(8'h38, 32'h0000_07FF, "R2 cfg width");
      exp_reg(8'h30, 32'h0, "R2 unmapped");
      wr(8'h04, 32'h1234_5678);
      exp_reg(8'h04, 32'h1234_5678, "R2 arg");
      wr(8'h38, 32'h0000_0400);

      // R4 / R9 short reply with busy-wait enabled
      wr(8'h00, 32'h0000_8811);
      card(1, 6'd17, 32'h1234_5678, 5'd4, 1'b0, {96'h0, 32'hDDCC_BBAA}, "R3 issue");
      exp_reg(8'h00, 32'h0000_0811, "R3 start bit clears");
      exp_reg(8'h10, 32'hAABB_CCDD, "R4 rsp0");
      exp_reg(8'h14, 32'h0, "R4 rsp1"); exp_reg(8'h18, 32'h0, "R4 rsp2");
      exp_reg(8'h1C, 32'h0, "R4 rsp3");
      exp_reg(8'h20, 32'h0000_0400, "R9 busy irq set");
      exp_pin(1, 1'b1, "R10 irq high");
      exp_pin(2, 1'b0, "R11 busy low after capture");

      // R10 write-one-to-clear
      wr(8'h20, 32'h0000_0040);
      exp_reg(8'h20, 32'h0000_0400, "R10 zero bits keep");
      wr(8'h20, 32'h0000_0400);
      exp_reg(8'h20, 32'h0, "R10 cleared");
      exp_pin(1, 1'b0, "R10 irq low");

      // R5 long reply
      wr(8'h00, 32'h0000_8202);
      card(0, 6'd2, 32'h1234_5678, 5'd16, 1'b0, long_bytes, "R5 issue");
      exp_reg(8'h10, 32'h1C1D_1E1F, "R5 rsp0");
      exp_reg(8'h14, 32'h1819_1A1B, "R5 rsp1");
      exp_reg(8'h18, 32'h1415_1617, "R5 rsp2");
      exp_reg(8'h1C, 32'h1011_1213, "R5 rsp3");
      exp_reg(8'h00, 32'h0000_0202, "R5 no fail");
      exp_reg(8'h20, 32'h0, "R5 sts");

      // R6 short reply to a long command
      wr(8'h00, 32'h0000_8209);
      card(0, 6'd9, 32'h1234_5678, 5'd4, 1'b0, {96'h0, 32'h5555_5555}, "R6 issue");
      exp_reg(8'h00, 32'h0000_4209, "R8 fail flag");
      exp_reg(8'h20, 32'h0000_0040, "R8 timeout bit");
      exp_reg(8'h10, 32'h1C1D_1E1F, "R8 rsp kept");
      exp_pin(1, 1'b0, "R10 timeout no irq");
      wr(8'h20, 32'h0000_0040);

      // R6 zero length
      wr(8'h00, 32'h0000_800D);
      card(0, 6'd13, 32'h1234_5678, 5'd0, 1'b0, 128'h0, "R6 zero");
      exp_reg(8'h00, 32'h0000_400D, "R6 zero length fails");
      exp_reg(8'h20, 32'h0000_0040, "R6 zero timeout");
      wr(8'h20, 32'h0000_0040);

      // R6 odd length
      wr(8'h00, 32'h0000_8007);
      card(0, 6'd7, 32'h1234_5678, 5'd7, 1'b0, 128'h0, "R6 odd");
      exp_reg(8'h00, 32'h0000_4007, "R6 odd length fails");
      exp_reg(8'h18, 32'h1415_1617, "R8 rsp2 kept");
      wr(8'h20, 32'h0000_0040);

      // R7 card error with busy-wait enabled
      wr(8'h00, 32'h0000_8811);
      card(0, 6'd17, 32'h1234_5678, 5'd4, 1'b1, 128'h0, "R7 err");
      exp_reg(8'h00, 32'h0000_4811, "R7 card error fails");
      exp_reg(8'h20, 32'h0000_0040, "R9 no busy irq on error");
      exp_pin(1, 1'b0, "R9 irq low on error");
      wr(8'h20, 32'h0000_0040);

      // R7 no-reply command with zero bytes
      wr(8'h00, 32'h0000_8400);
      card(0, 6'd0, 32'h1234_5678, 5'd0, 1'b0, 128'hFF, "R7 norsp");
      exp_reg(8'h00, 32'h0000_0400, "R7 no reply passes");
      exp_reg(8'h20, 32'h0, "R7 no timeout");
      exp_reg(8'h10, 32'h1C1D_1E1F, "R7 rsp untouched");

      // R9 busy-wait with enable clear
      wr(8'h38, 32'h0);
      wr(8'h00, 32'h0000_8805);
      card(2, 6'd5, 32'h1234_5678, 5'd4, 1'b0, {96'h0, 32'h0403_0201}, "R9 gated");
      exp_reg(8'h10, 32'h0102_0304, "R4 rsp0 second");
      exp_reg(8'h20, 32'h0, "R9 gated off");
      exp_pin(1, 1'b0, "R9 irq gated");

      // R3 write without start bit, upper bits dropped
      wr(8'h00, 32'hFFFF_0123);
      exp_reg(8'h00, 32'h0000_0123, "R3 stored no start");
      exp_pin(2, 1'b0, "R3 no issue");

      // R11 command write while busy
      wr(8'h04, 32'hCAFE_F00D);
      wr(8'h00, 32'h0000_8003);
      wr(8'h00, 32'h0000_8030);
      card(0, 6'd3, 32'hCAFE_F00D, 5'd4, 1'b0, {96'h0, 32'h4433_2211}, "R11 busy");
      exp_reg(8'h00, 32'h0000_0003, "R11 write ignored");
      exp_reg(8'h10, 32'h1122_3344, "R11 rsp0");
      exp_pin(2, 1'b0, "R11 no second issue");

      drain();
      repeat (2) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule